// File: doc/BRIEF.md
# Interleaved Banked Pseudo-Dual-Port RAM

An 8 KB word-addressed memory built from eight single-ported 1 KB banks. A processor sees it through two request ports: a read-only instruction port and a read/write data port. Consecutive four-word lines are spread across the banks. Requests from the two ports that land in different banks are served in the same cycle. When both land in one bank in the same cycle, the data side takes the bank and the instruction request waits.

The data port is shared by two masters: the processor's data bus and an external bus master used for test access, loading code or data, and DMA. A round-robin arbiter picks one of them each cycle. Every port uses a valid/ready request handshake. A read answers exactly one cycle after acceptance, with a response valid on the port that asked. A write is accepted and then forgotten: it returns no response.

Top module: `banked_pdp_ram`

## Requirements
- R1: While reset is held and in the first cycle after it, `i_rvalid`, `p_rvalid` and `x_rvalid` are low, and no ready is high without a matching valid.
- R2: The bank is byte-address bits [6:4]. The word within the bank is {bits [12:7], bits [3:2]}. Bits [1:0] are ignored. Each of the 2048 word addresses is distinct storage, shared by all ports.
- R3: The instruction port can only read. A read returns the last word written to that address from either data master.
- R4: If the instruction request and the chosen data request address the same bank in one cycle, `i_ready` is low. The instruction request is served in the first cycle with no such clash, and it must stay asserted with an unchanged address until then.
- R5: If the two requests address different banks, both are accepted in the same cycle. A chosen data request is never stalled by the instruction port.
- R6: `p_ready` and `x_ready` are never high together.
- R7: A data master that requests alone is granted at once. When both request, the one not served most recently is granted. After reset the processor data master goes first.
- R8: A read accepted in cycle N raises the requesting port's rvalid in cycle N+1, with the data on that port's rdata in the same cycle. Otherwise rvalid is low.
- R9: A write is complete when its ready is seen. It raises no rvalid, and a read accepted in the next cycle returns the new word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| i_valid | input | 1 | Instruction read request |
| i_addr | input | 13 | Instruction byte address |
| i_ready | output | 1 | Instruction request accepted this cycle |
| i_rvalid | output | 1 | Instruction read data valid |
| i_rdata | output | 32 | Instruction read data |
| p_valid | input | 1 | Processor data request |
| p_write | input | 1 | Processor request is a write |
| p_addr | input | 13 | Processor byte address |
| p_wdata | input | 32 | Processor write data |
| p_ready | output | 1 | Processor request accepted this cycle |
| p_rvalid | output | 1 | Processor read data valid |
| p_rdata | output | 32 | Processor read data |
| x_valid | input | 1 | External master request |
| x_write | input | 1 | External request is a write |
| x_addr | input | 13 | External byte address |
| x_wdata | input | 32 | External write data |
| x_ready | output | 1 | External request accepted this cycle |
| x_rvalid | output | 1 | External read data valid |
| x_rdata | output | 32 | External read data |

## Verification
The readies are combinational, so they are due in the same cycle as the request. The bench checks them 1 ns after it drives each input set, against a behavioural model of bank clashes and round-robin order. Read responses are due one clock later. The model queues the expected rvalid and data at acceptance and compares them at the next falling edge, which is also where it confirms that no response follows a write. The bench fills every word first, then runs directed clashes, alternation and write-then-read cases, and then a long random mix in which a stalled instruction request is held until it is accepted.

// File: rtl/bpr_pkg.sv
package bpr_pkg;
   // which master currently owns the shared data port
   typedef enum logic {
      OWN_PROC = 1'b0,
      OWN_EXT  = 1'b1
   } dmaster_e;
endpackage

// File: rtl/bpr_addr_split.sv
module bpr_addr_split #(
   parameter int ADDR_W    = 13,
   parameter int OFS_BITS  = 2,
   parameter int LINE_BITS = 2,
   parameter int BANK_BITS = 3,
   parameter int IDX_W     = 8
) (
   input  logic [ADDR_W-1:0]    addr,
   output logic [BANK_BITS-1:0] bank,
   output logic [IDX_W-1:0]     idx
);
   localparam int BANK_LSB = OFS_BITS + LINE_BITS;
   localparam int ROW_LSB  = BANK_LSB + BANK_BITS;

   if (IDX_W != ADDR_W - OFS_BITS - BANK_BITS) begin : g_bad_idx
      $error("bpr_addr_split: IDX_W does not match the address split");
   end

   // line-interleaved: neighbouring lines fall into neighbouring banks
   assign bank = addr[BANK_LSB +: BANK_BITS];
   assign idx  = {addr[ADDR_W-1:ROW_LSB], addr[OFS_BITS +: LINE_BITS]};

   logic [OFS_BITS-1:0] unused_ofs;
   assign unused_ofs = addr[OFS_BITS-1:0];
endmodule

// File: rtl/bpr_bank.sv
module bpr_bank #(
   parameter int DATA_W = 32,
   parameter int IDX_W  = 8
) (
   input  logic              clk,
   input  logic              en,
   input  logic              we,
   input  logic [IDX_W-1:0]  idx,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata
);
   localparam int DEPTH = 1 << IDX_W;

   logic [DATA_W-1:0] mem_q [DEPTH];
   logic [DATA_W-1:0] rd_q;

   // one access per cycle: either a write or a registered read
   always_ff @(posedge clk) begin
      if (en) begin
         if (we) mem_q[idx] <= wdata;
         else    rd_q       <= mem_q[idx];
      end
   end

   assign rdata = rd_q;
endmodule

// File: rtl/bpr_dmaster_arb.sv
module bpr_dmaster_arb (
   input  logic clk,
   input  logic rst_n,
   input  logic p_req,
   input  logic x_req,
   output logic p_gnt,
   output logic x_gnt
);
   logic prefer_x_q;

   // the data side never stalls, so each grant completes in its own cycle
   assign x_gnt = x_req && (!p_req || prefer_x_q);
   assign p_gnt = p_req && !x_gnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     prefer_x_q <= 1'b0;
      else if (p_gnt) prefer_x_q <= 1'b1;
      else if (x_gnt) prefer_x_q <= 1'b0;
   end

   AST_DMASTER_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(p_gnt && x_gnt)); // R6
   AST_RR_AFTER_PROC: assert property (@(posedge clk) disable iff (!rst_n)
      (p_req && x_req && p_gnt) |=> !(p_req && x_req && p_gnt)); // R7
   AST_RR_AFTER_EXT: assert property (@(posedge clk) disable iff (!rst_n)
      (p_req && x_req && x_gnt) |=> !(p_req && x_req && x_gnt)); // R7
endmodule

// File: rtl/banked_pdp_ram.sv
module banked_pdp_ram #(
   parameter int DATA_W     = 32,
   parameter int NUM_BANKS  = 8,
   parameter int BANK_BYTES = 1024,
   parameter int LINE_WORDS = 4,
   parameter int ADDR_W     = 13
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              i_valid,
   input  logic [ADDR_W-1:0] i_addr,
   output logic              i_ready,
   output logic              i_rvalid,
   output logic [DATA_W-1:0] i_rdata,
   input  logic              p_valid,
   input  logic              p_write,
   input  logic [ADDR_W-1:0] p_addr,
   input  logic [DATA_W-1:0] p_wdata,
   output logic              p_ready,
   output logic              p_rvalid,
   output logic [DATA_W-1:0] p_rdata,
   input  logic              x_valid,
   input  logic              x_write,
   input  logic [ADDR_W-1:0] x_addr,
   input  logic [DATA_W-1:0] x_wdata,
   output logic              x_ready,
   output logic              x_rvalid,
   output logic [DATA_W-1:0] x_rdata
);
   import bpr_pkg::*;

   localparam int WORD_BYTES = DATA_W / 8;
   localparam int OFS_BITS   = $clog2(WORD_BYTES);
   localparam int BANK_BITS  = $clog2(NUM_BANKS);
   localparam int LINE_BITS  = $clog2(LINE_WORDS);
   localparam int BANK_WORDS = BANK_BYTES / WORD_BYTES;
   localparam int IDX_W      = $clog2(BANK_WORDS);

   if (DATA_W % 8 != 0 || WORD_BYTES != (1 << OFS_BITS)) begin : g_bad_width
      $error("banked_pdp_ram: DATA_W must be a power-of-two number of bytes");
   end
   if (NUM_BANKS != (1 << BANK_BITS) || LINE_WORDS != (1 << LINE_BITS)) begin : g_bad_pow2
      $error("banked_pdp_ram: NUM_BANKS and LINE_WORDS must be powers of two");
   end
   if (ADDR_W != $clog2(NUM_BANKS * BANK_BYTES)) begin : g_bad_addr
      $error("banked_pdp_ram: ADDR_W does not match the capacity");
   end
   if (IDX_W < LINE_BITS) begin : g_bad_line
      $error("banked_pdp_ram: a bank must hold at least one line");
   end

   // ---------------- data-port master selection ----------------
   logic     p_gnt, x_gnt;
   dmaster_e d_owner;

   bpr_dmaster_arb u_arb (
      .clk  (clk),
      .rst_n(rst_n),
      .p_req(p_valid),
      .x_req(x_valid),
      .p_gnt(p_gnt),
      .x_gnt(x_gnt)
   );

   assign d_owner = x_gnt ? OWN_EXT : OWN_PROC;

   logic              d_valid, d_write;
   logic [ADDR_W-1:0] d_addr;
   logic [DATA_W-1:0] d_wdata;

   assign d_valid = p_valid || x_valid;
   assign d_write = (d_owner == OWN_EXT) ? x_write : p_write;
   assign d_addr  = (d_owner == OWN_EXT) ? x_addr  : p_addr;
   assign d_wdata = (d_owner == OWN_EXT) ? x_wdata : p_wdata;

   // ---------------- address decode ----------------
   logic [BANK_BITS-1:0] i_bank, d_bank;
   logic [IDX_W-1:0]     i_idx,  d_idx;

   bpr_addr_split #(.ADDR_W(ADDR_W), .OFS_BITS(OFS_BITS), .LINE_BITS(LINE_BITS),
                    .BANK_BITS(BANK_BITS), .IDX_W(IDX_W)) u_isplit (
      .addr(i_addr), .bank(i_bank), .idx(i_idx));

   bpr_addr_split #(.ADDR_W(ADDR_W), .OFS_BITS(OFS_BITS), .LINE_BITS(LINE_BITS),
                    .BANK_BITS(BANK_BITS), .IDX_W(IDX_W)) u_dsplit (
      .addr(d_addr), .bank(d_bank), .idx(d_idx));

   // ---------------- per-bank collision rule: data side wins ----------------
   logic i_go;
   assign i_go    = i_valid && !(d_valid && (d_bank == i_bank));
   assign i_ready = i_go;
   assign p_ready = p_gnt;
   assign x_ready = x_gnt;

   logic [DATA_W-1:0] bank_rd [NUM_BANKS];

   for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      logic             sel_d, sel_i;
      logic [IDX_W-1:0] b_idx;

      assign sel_d = d_valid && (d_bank == BANK_BITS'(b));
      assign sel_i = i_go    && (i_bank == BANK_BITS'(b));
      assign b_idx = sel_d ? d_idx : i_idx;

      bpr_bank #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_bank (
         .clk  (clk),
         .en   (sel_d || sel_i),
         .we   (sel_d && d_write),
         .idx  (b_idx),
         .wdata(d_wdata),
         .rdata(bank_rd[b])
      );

      AST_BANK_ONE_USER: assert property (@(posedge clk) disable iff (!rst_n)
         !(sel_d && sel_i)); // R4
   end

   // ---------------- response path ----------------
   logic                 i_rv_q, p_rv_q, x_rv_q;
   logic [BANK_BITS-1:0] i_bank_q, d_bank_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         i_rv_q   <= 1'b0;
         p_rv_q   <= 1'b0;
         x_rv_q   <= 1'b0;
         i_bank_q <= '0;
         d_bank_q <= '0;
      end else begin
         i_rv_q <= i_go;
         p_rv_q <= p_gnt && !p_write;
         x_rv_q <= x_gnt && !x_write;
         if (i_go)    i_bank_q <= i_bank;
         if (d_valid) d_bank_q <= d_bank;
      end
   end

   assign i_rvalid = i_rv_q;
   assign p_rvalid = p_rv_q;
   assign x_rvalid = x_rv_q;
   assign i_rdata  = bank_rd[i_bank_q];
   assign p_rdata  = bank_rd[d_bank_q];
   assign x_rdata  = bank_rd[d_bank_q];

   AST_CLASH_SPLIT: assert property (@(posedge clk) disable iff (!rst_n)
      (i_ready && (p_ready || x_ready)) |-> (i_bank != d_bank)); // R4
   AST_DATA_NO_STALL: assert property (@(posedge clk) disable iff (!rst_n)
      (p_valid || x_valid) |-> (p_ready || x_ready)); // R5
   AST_ILAT: assert property (@(posedge clk) disable iff (!rst_n)
      i_rvalid |-> $past(i_valid)); // R8
   AST_WRITE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
      (p_ready && p_write) |=> !p_rvalid); // R9
   AST_XWRITE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
      (x_ready && x_write) |=> !x_rvalid); // R9
endmodule

// File: tb/tb_banked_pdp_ram.sv
module tb_banked_pdp_ram;
   localparam int DW = 32;
   localparam int AW = 13;
   localparam int NW = 2048;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2 clk = ~clk;

   logic          iv, pv, pw, xv, xw;
   logic [AW-1:0] ia, pa, xa;
   logic [DW-1:0] pd, xd;
   logic          i_ready, i_rvalid, p_ready, p_rvalid, x_ready, x_rvalid;
   logic [DW-1:0] i_rdata, p_rdata, x_rdata;

   banked_pdp_ram dut (
      .clk(clk), .rst_n(rst_n),
      .i_valid(iv), .i_addr(ia), .i_ready(i_ready), .i_rvalid(i_rvalid), .i_rdata(i_rdata),
      .p_valid(pv), .p_write(pw), .p_addr(pa), .p_wdata(pd),
      .p_ready(p_ready), .p_rvalid(p_rvalid), .p_rdata(p_rdata),
      .x_valid(xv), .x_write(xw), .x_addr(xa), .x_wdata(xd),
      .x_ready(x_ready), .x_rvalid(x_rvalid), .x_rdata(x_rdata)
   );

   logic [DW-1:0] ref_mem [NW];
   bit            prefer_x;
   bit            e_irv, e_prv, e_xrv, wr_last;
   logic [DW-1:0] e_ird, e_prd, e_xrd;
   bit            i_stall, p_wait, x_wait;
   int            checks = 0;
   int            errors = 0;
   bit            finished = 0;

   task automatic chk(bit ok, string tag, string what, logic [DW-1:0] act, logic [DW-1:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
      end
   endtask

   function automatic logic [2:0] bk(logic [AW-1:0] a);
      return a[6:4];
   endfunction

   function automatic logic [AW-1:0] mk(int bank, int row, int word, int ofs);
      return {6'(row), 3'(bank), 2'(word), 2'(ofs)};
   endfunction

   // called just after a falling edge with the inputs already driven
   task automatic cycle();
      bit gx, gp, dv, ig, same;
      logic [AW-1:0] da;
      #1;
      gx   = xv && (!pv || prefer_x);
      gp   = pv && !gx;
      dv   = pv || xv;
      da   = gx ? xa : pa;
      same = iv && dv && (bk(ia) == bk(da));
      ig   = iv && !same;
      chk(i_ready == ig, same ? "R4" : "R5", "i_ready", 32'(i_ready), 32'(ig));
      chk(p_ready == gp, "R7", "p_ready", 32'(p_ready), 32'(gp));
      chk(x_ready == gx, "R7", "x_ready", 32'(x_ready), 32'(gx));
      chk(!(p_ready && x_ready), "R6", "both data grants", 32'({p_ready, x_ready}), 32'd0);
      e_irv = ig;
      if (ig) e_ird = ref_mem[ia[12:2]];
      e_prv = gp && !pw;
      if (e_prv) e_prd = ref_mem[pa[12:2]];
      e_xrv = gx && !xw;
      if (e_xrv) e_xrd = ref_mem[xa[12:2]];
      wr_last = (gp && pw) || (gx && xw);
      if (gp && pw) ref_mem[pa[12:2]] = pd;
      if (gx && xw) ref_mem[xa[12:2]] = xd;
      if (gp) prefer_x = 1'b1;
      else if (gx) prefer_x = 1'b0;
      i_stall = iv && !ig;
      p_wait  = pv && !gp;
      x_wait  = xv && !gx;
      @(negedge clk);
      chk(i_rvalid == e_irv, "R8", "i_rvalid", 32'(i_rvalid), 32'(e_irv));
      chk(p_rvalid == e_prv, wr_last ? "R9" : "R8", "p_rvalid", 32'(p_rvalid), 32'(e_prv));
      chk(x_rvalid == e_xrv, wr_last ? "R9" : "R8", "x_rvalid", 32'(x_rvalid), 32'(e_xrv));
      if (e_irv) chk(i_rdata == e_ird, "R3", "i_rdata", i_rdata, e_ird);
      if (e_prv) chk(p_rdata == e_prd, "R2", "p_rdata", p_rdata, e_prd);
      if (e_xrv) chk(x_rdata == e_xrd, "R2", "x_rdata", x_rdata, e_xrd);
   endtask

   task automatic idle_inputs();
      iv = 0; pv = 0; xv = 0; pw = 0; xw = 0;
      ia = '0; pa = '0; xa = '0; pd = '0; xd = '0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         errors++;
         $display("FAIL watchdog run did not finish actual=%0d expected=%0d", 0, 1);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      idle_inputs();
      prefer_x = 0;
      repeat (3) @(negedge clk);
      // R1: quiet outputs during reset
      chk(!i_rvalid && !p_rvalid && !x_rvalid, "R1", "rvalids in reset",
          32'({i_rvalid, p_rvalid, x_rvalid}), 32'd0);
      chk(!i_ready && !p_ready && !x_ready, "R1", "readies in reset",
          32'({i_ready, p_ready, x_ready}), 32'd0);
      rst_n = 1'b1;
      #1;
      chk(!i_rvalid && !p_rvalid && !x_rvalid, "R1", "rvalids after reset",
          32'({i_rvalid, p_rvalid, x_rvalid}), 32'd0);

      // fill every word, alternating masters, with random low address bits (R2, R9)
      for (int w = 0; w < NW; w++) begin
         idle_inputs();
         if (w % 2 == 0) begin
            pv = 1; pw = 1; pa = AW'({w[10:0], 2'(w * 7)}); pd = $urandom;
         end else begin
            xv = 1; xw = 1; xa = AW'({w[10:0], 2'(w * 3)}); xd = $urandom;
         end
         cycle();
      end

      // R4: same bank, data side wins, instruction held then served
      idle_inputs();
      iv = 1; ia = mk(3, 5, 1, 0);
      pv = 1; pw = 0; pa = mk(3, 9, 2, 0);
      cycle();
      pv = 0;
      cycle();
      // R4: clash with external master write, then instruction reads the new word
      iv = 1; ia = mk(6, 1, 0, 0);
      xv = 1; xw = 1; xa = mk(6, 1, 0, 2); xd = 32'hCAFE_0006;
      cycle();
      xv = 0;
      cycle();
      // R5: different banks in parallel
      idle_inputs();
      iv = 1; ia = mk(2, 4, 3, 0);
      pv = 1; pw = 0; pa = mk(5, 4, 3, 0);
      cycle();
      // R9: write then read the same word next cycle
      idle_inputs();
      pv = 1; pw = 1; pa = mk(1, 63, 3, 0); pd = 32'h1234_ABCD;
      cycle();
      idle_inputs();
      iv = 1; ia = mk(1, 63, 3, 1);
      xv = 1; xw = 0; xa = mk(1, 63, 3, 3);
      cycle();
      cycle();
      // R2: words differing only in bank bits are separate
      idle_inputs();
      pv = 1; pw = 1; pa = mk(0, 10, 0, 0); pd = 32'hA0A0_0000;
      cycle();
      pa = mk(7, 10, 0, 0); pd = 32'hA7A7_0007;
      cycle();
      pw = 0; pa = mk(0, 10, 0, 3);
      cycle();
      pa = mk(7, 10, 0, 1);
      cycle();
      // R7: both data masters request continuously
      idle_inputs();
      for (int k = 0; k < 8; k++) begin
         pv = 1; pw = 0; pa = mk(k % 8, k, 1, 0);
         xv = 1; xw = 0; xa = mk((k + 3) % 8, k + 1, 2, 0);
         cycle();
      end
      idle_inputs();
      cycle();

      // random mix; stalled or losing requests are held
      for (int n = 0; n < 3000; n++) begin
         if (!i_stall) begin
            iv = ($urandom % 3) != 0;
            ia = AW'($urandom);
         end
         if (!p_wait) begin
            pv = ($urandom % 2) != 0;
            pw = ($urandom % 3) == 0;
            pa = AW'($urandom);
            pd = $urandom;
         end
         if (!x_wait) begin
            xv = ($urandom % 3) == 0;
            xw = ($urandom % 2) == 0;
            xa = AW'($urandom);
            xd = $urandom;
         end
         cycle();
      end
      idle_inputs();
      cycle();

      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule